// File: doc/BRIEF.md
# Tape Block Sync and Framer

This block sits behind a tape bit decoder. It takes one decoded bit per strobe and keeps its own 16-bit history of the most recent bits. It waits until that history shows the sync-plus-start word, then frames a block of fixed length. The block is cut into bytes, which are sent out least significant bit first. Only the header and payload bytes appear on the byte output. The block then ends with a trailer byte and a two-byte checksum, and the framer checks both. A decoder timeout or a motor-off event in the middle of a block abandons it, and the framer goes back to hunting.

The framer also owns the bit-rate setting. When a block marked as a header ends, a rate calculator takes the divisor byte from that block and derives the quarter-bit period for the decoder, together with a prescale-by-8 select. It does this with a shared serial divider. Motor-off, and reset, restore the default rate.

Framer states: ST_HUNT (compare the history after every bit), ST_PAYLOAD (bytes 0 to 255), ST_ETX (trailer byte), ST_CSUM_LO and ST_CSUM_HI (checksum bytes). The transitions are:
- hunt to payload on a sync hit;
- payload to trailer after byte 255;
- trailer to checksum low after one byte;
- checksum low to checksum high after one byte;
- checksum high to hunt after one byte;
- any state to hunt on an abort.

Rate calculator states: RC_KICK (start the baud division), RC_BAUD (wait for it, then start the period division), RC_QP (wait, then publish), RC_IDLE. A request in any state moves the calculator to RC_KICK.

Top module: `tape_block_framer`

## Requirements
- R1: While hunting, after every bit strobe the framer compares the last 16 bits with 0x0216. The first-received bit is in bit 0 and the newest bit is in bit 15, so the stream carries 0x16 and then 0x02, each least significant bit first. Only a match starts a block, and rx_active goes high in the cycle after the matching strobe.
- R2: A block is 259 bytes of 8 bits each, received least significant bit first. Byte 0 is the type, bytes 1 and 2 are the number, bytes 3 to 255 are data, byte 256 is the trailer, and bytes 257 and 258 are the checksum low and high bytes. Bytes 0 to 255 are presented on byte_data with a one-cycle byte_valid in the cycle after the strobe of their eighth bit. Bytes 256 to 258 are never presented.
- R3: The bit history is cleared after every byte. A block whose two checksum bytes spell the sync word therefore does not start a new block once it ends.
- R4: The checksum is 0x0003 plus bytes 0 to 255, taken modulo 65536. A mismatch with the received checksum raises csum_err for one cycle after the final byte.
- R5: A trailer byte other than 0x03 raises frame_err for one cycle after that byte.
- R6: rx_active stays high from the cycle after the sync hit until the strobe of the last checksum bit, and it is low from the cycle after that strobe.
- R7: When a block with a nonzero byte 0 ends, the rate is recalculated from byte 14. A byte 14 of zero selects the default divisor of 255. rate_update pulses for one cycle when the new values appear.
- R8: baud = floor((192000 + floor(d/2) - 1) / d). If baud < 976, prescale8 is 1 and baud is multiplied by 8. quarter_period = floor(16000000 / (4 × baud)), and it changes only together with rate_update.
- R9: After reset rx_active and all strobes are low, and the default rate (quarter_period 664, prescale8 1) is published.
- R10: A bit_timeout in mid-block drops rx_active in the next cycle. No further bytes are presented, and hunting resumes.
- R11: motor_off aborts any block in the next cycle and republishes the default rate.
- R12: A block whose byte 0 is zero leaves the rate unchanged and gives no rate_update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | One decoded bit is available |
| bit_val | input | 1 | Value of the decoded bit |
| bit_timeout | input | 1 | Decoder found no clock edge in time |
| motor_off | input | 1 | Tape motor switched off |
| byte_data | output | 8 | Received header or payload byte |
| byte_valid | output | 1 | byte_data is new this cycle |
| frame_err | output | 1 | Trailer byte was wrong |
| csum_err | output | 1 | Checksum mismatch |
| rx_active | output | 1 | A block is being received |
| rate_update | output | 1 | New rate values published |
| quarter_period | output | 16 | Quarter-bit period in counter ticks |
| prescale8 | output | 1 | Counter clock divided by 8 |

## Verification
The assertions take for granted that bit_timeout and motor_off never arrive in the same cycle as a bit strobe, and that a new rate request never arrives while a calculation is running. The bench honours this by issuing strobes one cycle in every two. It also pulses the abort inputs only on cycles without a strobe, and it waits for each rate_update before it sends anything that could request another.

// File: rtl/tape_framer_pkg.sv
package tape_framer_pkg;
    localparam int          HIST_W      = 16;
    localparam logic [15:0] SYNC_WORD   = 16'h0216;
    localparam logic [7:0]  TRAILER     = 8'h03;
    localparam logic [15:0] SUM_SEED    = 16'h0003;
    localparam int          SLOW_LIMIT  = 976;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PAYLOAD,
        ST_ETX,
        ST_CSUM_LO,
        ST_CSUM_HI
    } frm_state_t;

    typedef enum logic [1:0] {
        RC_IDLE,
        RC_KICK,
        RC_BAUD,
        RC_QP
    } rc_state_t;
endpackage

// File: rtl/tape_bit_history.sv
module tape_bit_history #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         bit_val,
    input  logic         clear,
    output logic [W-1:0] word_next
);
    logic [W-1:0] word_q;

    assign word_next = {bit_val, word_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (clear)  word_q <= '0;
        else if (strobe) word_q <= word_next;
    end
endmodule

// File: rtl/tape_serial_div.sv
module tape_serial_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    acc;
    logic [W-1:0]  dvs;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [W:0]    shifted;
    logic          fits;

    always_comb begin
        shifted = {acc[W-1:0], quotient[W-1]};
        fits    = shifted >= {1'b0, dvs};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0; dvs <= '0; cnt <= '0; busy <= 1'b0;
            done <= 1'b0; quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc      <= '0;
                dvs      <= divisor;
                quotient <= dividend;
                cnt      <= CW'(W);
                busy     <= 1'b1;
            end else if (busy) begin
                acc      <= fits ? shifted - {1'b0, dvs} : shifted;
                quotient <= {quotient[W-2:0], fits};
                cnt      <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tape_rate_calc.sv
module tape_rate_calc
    import tape_framer_pkg::*;
#(
    parameter int unsigned BASE_CLK    = 192000,
    parameter int unsigned CNT_CLK     = 16000000,
    parameter logic [7:0]  DEFAULT_DIV = 8'd255,
    parameter int          QW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [7:0]    req_div,
    output logic          update,
    output logic [QW-1:0] qp,
    output logic          presc
);
    localparam int          DW   = 32;
    localparam logic [DW-1:0] QMAX = DW'({QW{1'b1}});

    rc_state_t     state, state_n;
    logic [7:0]    div_r;
    logic          slow_r;
    logic          dv_start, dv_done, slow;
    logic [DW-1:0] dv_dividend, dv_divisor, dv_quo, baud_adj;

    tape_serial_div #(.W(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(dv_start),
        .dividend(dv_dividend), .divisor(dv_divisor),
        .done(dv_done), .quotient(dv_quo)
    );

    always_comb begin
        slow        = dv_quo < DW'(SLOW_LIMIT);
        baud_adj    = slow ? {dv_quo[DW-4:0], 3'b000} : dv_quo;
        dv_start    = (state == RC_KICK) || (state == RC_BAUD && dv_done);
        if (state == RC_KICK) begin
            dv_dividend = DW'(BASE_CLK) + DW'(div_r[7:1]) - DW'(1);
            dv_divisor  = DW'(div_r);
        end else begin
            dv_dividend = DW'(CNT_CLK);
            dv_divisor  = {baud_adj[DW-3:0], 2'b00};
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RC_IDLE: state_n = RC_IDLE;
            RC_KICK: state_n = RC_BAUD;
            RC_BAUD: if (dv_done) state_n = RC_QP;
            RC_QP:   if (dv_done) state_n = RC_IDLE;
            default: state_n = RC_IDLE;
        endcase
        if (req) state_n = RC_KICK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RC_KICK;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_r <= DEFAULT_DIV; slow_r <= 1'b0;
            update <= 1'b0; qp <= '0; presc <= 1'b0;
        end else begin
            update <= 1'b0;
            if (req) begin
                div_r <= (req_div == 8'd0) ? DEFAULT_DIV : req_div;
            end else if (state == RC_BAUD && dv_done) begin
                slow_r <= slow;
            end else if (state == RC_QP && dv_done) begin
                qp     <= (dv_quo > QMAX) ? QMAX[QW-1:0] : dv_quo[QW-1:0];
                presc  <= slow_r;
                update <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tape_framer_fsm.sv
module tape_framer_fsm
    import tape_framer_pkg::*;
#(
    parameter int DATA_LEN = 253,
    parameter int NAME_LEN = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [HIST_W-1:0] word_next,
    input  logic              timeout,
    input  logic              motor_off,
    output logic              hist_clear,
    output logic [7:0]        byte_data,
    output logic              byte_valid,
    output logic              frame_err,
    output logic              csum_err,
    output logic              rx_active,
    output logic              rate_req,
    output logic [7:0]        rate_div
);
    localparam int HDR_LEN = 3;
    localparam int PAY_LEN = HDR_LEN + DATA_LEN;
    localparam int IW      = $clog2(PAY_LEN);
    localparam int DIV_IDX = HDR_LEN + NAME_LEN;

    frm_state_t    state, state_n;
    logic [2:0]    bit_cnt;
    logic [IW-1:0] idx;
    logic [15:0]   sum;
    logic [7:0]    hdr_flag, div_byte, sum_lo, cur;
    logic          abort, in_block, byte_done, sync_hit, last_pay;

    always_comb begin
        cur        = word_next[HIST_W-1 -: 8];
        abort      = timeout | motor_off;
        in_block   = state != ST_HUNT;
        byte_done  = strobe && in_block && (bit_cnt == 3'd7) && !abort;
        sync_hit   = strobe && !in_block && (word_next == SYNC_WORD) && !abort;
        last_pay   = idx == IW'(PAY_LEN - 1);
        hist_clear = abort | byte_done;
        rx_active  = in_block;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT:    if (sync_hit) state_n = ST_PAYLOAD;
            ST_PAYLOAD: if (byte_done && last_pay) state_n = ST_ETX;
            ST_ETX:     if (byte_done) state_n = ST_CSUM_LO;
            ST_CSUM_LO: if (byte_done) state_n = ST_CSUM_HI;
            ST_CSUM_HI: if (byte_done) state_n = ST_HUNT;
            default:    state_n = ST_HUNT;
        endcase
        if (abort) state_n = ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0; idx <= '0; sum <= '0;
            hdr_flag <= '0; div_byte <= '0; sum_lo <= '0;
            byte_data <= '0; byte_valid <= 1'b0; frame_err <= 1'b0;
            csum_err <= 1'b0; rate_req <= 1'b0; rate_div <= '0;
        end else begin
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            csum_err   <= 1'b0;
            rate_req   <= 1'b0;
            if (abort) begin
                bit_cnt <= '0;
                idx     <= '0;
            end else if (sync_hit) begin
                bit_cnt <= '0;
                idx     <= '0;
                sum     <= SUM_SEED;
            end else if (strobe && in_block) begin
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_done) begin
                    unique case (state)
                        ST_PAYLOAD: begin
                            byte_data  <= cur;
                            byte_valid <= 1'b1;
                            sum        <= sum + {8'd0, cur};
                            idx        <= idx + 1'b1;
                            if (idx == '0) hdr_flag <= cur;
                            if (idx == IW'(DIV_IDX)) div_byte <= cur;
                        end
                        ST_ETX:     frame_err <= (cur != TRAILER);
                        ST_CSUM_LO: sum_lo <= cur;
                        ST_CSUM_HI: begin
                            csum_err <= ({cur, sum_lo} != sum);
                            rate_req <= (hdr_flag != 8'd0);
                            rate_div <= div_byte;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/tape_block_framer.sv
module tape_block_framer
    import tape_framer_pkg::*;
#(
    parameter int unsigned BASE_CLK    = 192000,
    parameter int unsigned CNT_CLK     = 16000000,
    parameter logic [7:0]  DEFAULT_DIV = 8'd255,
    parameter int          DATA_LEN    = 253,
    parameter int          NAME_LEN    = 11,
    parameter int          QW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_strobe,
    input  logic          bit_val,
    input  logic          bit_timeout,
    input  logic          motor_off,
    output logic [7:0]    byte_data,
    output logic          byte_valid,
    output logic          frame_err,
    output logic          csum_err,
    output logic          rx_active,
    output logic          rate_update,
    output logic [QW-1:0] quarter_period,
    output logic          prescale8
);
    logic [HIST_W-1:0] word_next;
    logic              hist_clear, rate_req;
    logic [7:0]        rate_div;

    tape_bit_history #(.W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .strobe(bit_strobe), .bit_val(bit_val),
        .clear(hist_clear), .word_next(word_next)
    );

    tape_framer_fsm #(.DATA_LEN(DATA_LEN), .NAME_LEN(NAME_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(bit_strobe), .word_next(word_next),
        .timeout(bit_timeout), .motor_off(motor_off), .hist_clear(hist_clear),
        .byte_data(byte_data), .byte_valid(byte_valid), .frame_err(frame_err),
        .csum_err(csum_err), .rx_active(rx_active), .rate_req(rate_req),
        .rate_div(rate_div)
    );

    tape_rate_calc #(
        .BASE_CLK(BASE_CLK), .CNT_CLK(CNT_CLK),
        .DEFAULT_DIV(DEFAULT_DIV), .QW(QW)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .req(rate_req | motor_off),
        .req_div(motor_off ? 8'd0 : rate_div),
        .update(rate_update), .qp(quarter_period), .presc(prescale8)
    );
endmodule

// File: rtl/tape_framer_sva.sv
module tape_framer_sva #(
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_strobe,
    input logic          bit_timeout,
    input logic          motor_off,
    input logic          byte_valid,
    input logic          frame_err,
    input logic          csum_err,
    input logic          rx_active,
    input logic          rate_update,
    input logic [QW-1:0] quarter_period
);
    AST_BYTE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(bit_strobe)); // R2
    AST_BYTE_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> rx_active); // R6
    AST_FRAME_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ($past(bit_strobe) && $past(rx_active))); // R5
    AST_CSUM_ENDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err |-> (!rx_active && $past(rx_active) && !frame_err)); // R4
    AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_timeout |=> !rx_active); // R10
    AST_MOTOR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        motor_off |=> !rx_active); // R11
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_update |-> $stable(quarter_period)); // R8
    AST_RATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rate_update |-> (quarter_period != '0)); // R8
endmodule

bind tape_block_framer tape_framer_sva #(.QW(QW)) u_sva (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe),
    .bit_timeout(bit_timeout), .motor_off(motor_off),
    .byte_valid(byte_valid), .frame_err(frame_err), .csum_err(csum_err),
    .rx_active(rx_active), .rate_update(rate_update),
    .quarter_period(quarter_period)
);

// File: tb/tape_block_framer_tb.sv
module tape_block_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_strobe = 1'b0, bit_val = 1'b0;
    logic        bit_timeout = 1'b0, motor_off = 1'b0;
    logic [7:0]  byte_data;
    logic        byte_valid, frame_err, csum_err, rx_active, rate_update, prescale8;
    logic [15:0] quarter_period;

    int checks = 0, failures = 0;
    int ncap = 0, nfe = 0, ncs = 0, nrate = 0;
    logic [7:0] cap [0:1023];
    logic [7:0] blk [0:258];
    bit done_flag = 0;

    always #5 clk = ~clk;

    tape_block_framer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_val(bit_val),
        .bit_timeout(bit_timeout), .motor_off(motor_off),
        .byte_data(byte_data), .byte_valid(byte_valid), .frame_err(frame_err),
        .csum_err(csum_err), .rx_active(rx_active), .rate_update(rate_update),
        .quarter_period(quarter_period), .prescale8(prescale8)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                cap[ncap % 1024] = byte_data;
                ncap = ncap + 1;
            end
            if (frame_err) nfe = nfe + 1;
            if (csum_err) ncs = ncs + 1;
            if (rate_update) nrate = nrate + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [16:0] exp_rate(input int dv);
        longint d, baud, q;
        bit p;
        d = (dv == 0) ? 255 : dv;
        baud = (192000 + d / 2 - 1) / d;
        p = baud < 976;
        if (p) baud = baud * 8;
        q = 16000000 / (4 * baud);
        return {p, q[15:0]};
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_strobe = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_strobe = 1'b0;
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_sync;
        send_byte(8'h16);
        send_byte(8'h02);
    endtask

    task automatic make_block(input logic [7:0] typ, input logic [7:0] dv,
                              input bit bad_etx, input bit bad_sum, input int seed);
        logic [15:0] s;
        s = 16'h0003;
        for (int i = 0; i < 256; i++) blk[i] = 8'((i * 7 + seed) ^ (i >> 3));
        blk[0] = typ;
        blk[14] = dv;
        for (int i = 0; i < 256; i++) s = s + {8'd0, blk[i]};
        if (bad_sum) s = s ^ 16'h0100;
        blk[256] = bad_etx ? 8'h13 : 8'h03;
        blk[257] = s[7:0];
        blk[258] = s[15:8];
    endtask

    task automatic send_block(input string tag);
        int base, bad;
        base = ncap;
        send_sync();
        check({tag, " R1 active after sync"}, rx_active, 1);
        for (int i = 0; i < 258; i++) send_byte(blk[i]);
        for (int i = 0; i < 7; i++) send_bit(blk[258][i]);
        check({tag, " R6 active before last bit"}, rx_active, 1);
        send_bit(blk[258][7]);
        check({tag, " R6 idle after last bit"}, rx_active, 0);
        check({tag, " R2 byte count"}, ncap - base, 256);
        bad = 0;
        for (int i = 0; i < 256; i++) if (cap[(base + i) % 1024] !== blk[i]) bad++;
        check({tag, " R2 byte content mismatches"}, bad, 0);
    endtask

    task automatic wait_rate(input string tag, input int dv);
        int n0;
        logic [16:0] e;
        n0 = nrate;
        for (int i = 0; i < 400 && nrate == n0; i++) @(negedge clk);
        #1;
        e = exp_rate(dv);
        check({tag, " R7 rate_update seen"}, nrate - n0, 1);
        check({tag, " R8 quarter_period"}, quarter_period, e[15:0]);
        check({tag, " R8 prescale8"}, prescale8, e[16]);
    endtask

    task automatic t_reset;
        check("R9 rx_active reset", rx_active, 0);
        check("R9 byte_valid reset", byte_valid, 0);
        check("R9 error flags reset", frame_err | csum_err, 0);
        wait_rate("R9 default", 0);
    endtask

    task automatic t_good_block;
        int e0, r0;
        send_byte(8'hFF);
        send_byte(8'hA5);
        send_byte(8'h16);
        check("R1 no start on partial sync", rx_active, 0);
        send_byte(8'h02);
        check("R1 sync after noise", rx_active, 1);
        bit_timeout = 1'b1;
        @(negedge clk);
        bit_timeout = 1'b0;
        #1;
        e0 = nfe + ncs;
        r0 = nrate;
        make_block(8'h00, 8'd48, 0, 0, 5);
        send_block("good");
        repeat (200) @(negedge clk);
        check("R4 R5 no errors on good block", nfe + ncs - e0, 0);
        check("R12 no rate change for data block", nrate - r0, 0);
    endtask

    task automatic t_bad_etx;
        int f0, c0;
        f0 = nfe; c0 = ncs;
        make_block(8'h00, 8'd0, 1, 0, 11);
        send_block("etx");
        check("R5 frame_err on bad trailer", nfe - f0, 1);
        check("R4 checksum still fine", ncs - c0, 0);
    endtask

    task automatic t_bad_sum;
        int f0, c0;
        f0 = nfe; c0 = ncs;
        make_block(8'h00, 8'd0, 0, 1, 23);
        send_block("sum");
        check("R4 csum_err on mismatch", ncs - c0, 1);
        check("R5 trailer still fine", nfe - f0, 0);
    endtask

    task automatic t_header(input logic [7:0] typ, input int dv, input int seed);
        make_block(typ, 8'(dv), 0, 0, seed);
        send_block("header");
        wait_rate("R7 header", dv);
    endtask

    task automatic t_timeout;
        int n0;
        make_block(8'h00, 8'd0, 0, 0, 31);
        send_sync();
        for (int i = 0; i < 10; i++) send_byte(blk[i]);
        @(negedge clk);
        bit_timeout = 1'b1;
        @(negedge clk);
        bit_timeout = 1'b0;
        #1;
        check("R10 timeout drops active", rx_active, 0);
        n0 = ncap;
        for (int i = 10; i < 14; i++) send_byte(blk[i]);
        check("R10 no bytes after abort", ncap - n0, 0);
        check("R10 still hunting", rx_active, 0);
        send_block("after timeout");
    endtask

    task automatic t_sum_sync;
        int n0;
        for (int i = 0; i < 256; i++) blk[i] = 8'h00;
        blk[3] = 8'h16; blk[4] = 8'h02; blk[5] = 8'hFF; blk[6] = 8'hFC;
        blk[256] = 8'h03; blk[257] = 8'h16; blk[258] = 8'h02;
        send_block("sumsync");
        check("R3 sync-like checksum no restart", rx_active, 0);
        n0 = ncap;
        send_byte(8'h00);
        check("R3 stays idle", rx_active, 0);
        check("R3 no stray bytes", ncap - n0, 0);
    endtask

    task automatic t_motor;
        send_sync();
        for (int i = 0; i < 5; i++) send_byte(8'h5A);
        @(negedge clk);
        motor_off = 1'b1;
        @(negedge clk);
        motor_off = 1'b0;
        #1;
        check("R11 motor_off aborts", rx_active, 0);
        wait_rate("R11 default restore", 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_good_block();
        t_bad_etx();
        t_bad_sum();
        t_header(8'h01, 48, 41);
        t_header(8'h02, 0, 43);
        t_header(8'h01, 48, 47);
        t_motor();
        t_timeout();
        t_sum_sync();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule